// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block is the device-side control for a clocked burst read from a memory array of 16-bit words. It opens a burst on a rising clock edge where chip enable is high and the active-low address strobe is low, and captures the start word address on that edge. It then waits a programmed number of wait-state clocks and, from then on, presents one word address per clock. It flags each valid word and drives a ready output.

Four stepping modes exist. Linear mode counts up without bound. The three wrap modes keep the address inside an aligned group of 8, 16 or 32 words and wrap to the bottom of that group. Ready either marks the data cycles exactly or rises one clock before the first word, depending on a configuration bit. The array sits outside the block: it receives `word_addr` and returns `mem_q`, which the block passes to `data_out` while a word is valid.

Top module: `burst_seq_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rdy`, `data_vld` and `data_out` are 0. Reset loads mode linear, wait count 7 and ready-lead off, so a burst that has not been configured delivers its first word after 8 wait cycles.
- R2: A rising edge with `ce`=1 and `addr_valid_n`=0 captures `start_addr` and starts a burst. This also applies during a running burst, and the new address and a fresh wait count take over.
- R3: If the capture happens at edge 0 and the wait count is W, `data_vld` is 0 after edges 0..W and becomes 1 after edge W+1 with `word_addr` equal to the start address.
- R4: Mode code 00 (linear) adds 1 to `word_addr` on each clock of the burst and ignores group boundaries.
- R5: Mode code 01 wraps within the aligned 8-word group, so a start at 39h gives 39h..3Fh and then 38h.
- R6: Mode code 10 wraps within the aligned 16-word group.
- R7: Mode code 11 wraps within the aligned 32-word group.
- R8: With ready-lead at 0, `rdy` equals `data_vld` on every cycle.
- R9: With ready-lead at 1, `rdy` is 1 on the cycle after edge W, one clock before the first word, and stays 1 with the data.
- R10: A rising edge with `ce`=0 ends the burst. After that edge `rdy` and `data_vld` are 0, and the block stays idle until a new strobe.
- R11: `cfg_wr` at a rising edge loads `cfg_mode`, `cfg_wait` and `cfg_rdy_early` only when no burst is active. A write during a burst is dropped.
- R12: `data_out` equals `mem_q` while `data_vld` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_mode | input | 2 | Burst mode: 00 linear, 01 wrap 8, 10 wrap 16, 11 wrap 32 |
| cfg_wait | input | 3 | Number of initial wait-state clocks |
| cfg_rdy_early | input | 1 | 1 makes ready lead the first word by one clock |
| ce | input | 1 | Chip enable, active high |
| addr_valid_n | input | 1 | Address strobe, active low |
| start_addr | input | ADDR_W | Burst start word address |
| mem_q | input | DATA_W | Word returned by the array for `word_addr` |
| word_addr | output | ADDR_W | Current burst word address |
| data_out | output | DATA_W | Burst data word, zero when not valid |
| data_vld | output | 1 | A burst word is valid this cycle |
| rdy | output | 1 | Ready indication |

## Verification
The capture edge is edge 0. The first word is due after edge W+1, a lead-mode ready is due after edge W, and each later word is due one edge after the one before. An abort or a dropped configuration write shows up after the next single edge. Each scenario task drives its inputs 1 ns after a rising edge and samples the outputs at that same point. It therefore walks the burst edge by edge, and each check it makes is tied to a known edge count from the capture. The bench computes the expected address sequence with its own group arithmetic, and the expected data with its own array function.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;

    localparam int WAIT_W = 3;
    localparam int WRAP_W = 5;

    typedef enum logic [1:0] {
        BM_LINEAR = 2'b00,
        BM_WRAP8  = 2'b01,
        BM_WRAP16 = 2'b10,
        BM_WRAP32 = 2'b11
    } burst_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_DATA = 2'b10
    } seq_state_e;

    typedef struct packed {
        burst_mode_e       mode;
        logic [WAIT_W-1:0] wait_cnt;
        logic              rdy_early;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{mode: BM_LINEAR, wait_cnt: '1, rdy_early: 1'b0};

    // Low-order address bits that cycle inside a wrap group.
    function automatic logic [WRAP_W-1:0] wrap_mask(input burst_mode_e m);
        case (m)
            BM_WRAP8:  return 5'h07;
            BM_WRAP16: return 5'h0F;
            BM_WRAP32: return 5'h1F;
            default:   return 5'h00;
        endcase
    endfunction

endpackage

// File: rtl/bsq_cfg.sv
`timescale 1ns/1ps
module bsq_cfg
    import bsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       busy,
    input  burst_cfg_t cfg_in,
    output burst_cfg_t cfg_o
);
    burst_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (wr_en && !busy)
            cfg_q <= cfg_in;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/bsq_ctrl.sv
`timescale 1ns/1ps
module bsq_ctrl
    import bsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              strobe_n,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              rdy_early,
    output logic              start,
    output logic              advance,
    output logic              busy,
    output logic              data_vld,
    output logic              rdy
);
    seq_state_e        state_q;
    logic [WAIT_W-1:0] cnt_q;

    assign start = ce && !strobe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (!ce) begin
            state_q <= ST_IDLE;
        end else if (start) begin
            state_q <= ST_WAIT;
            cnt_q   <= wait_cfg;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (cnt_q == '0)
                        state_q <= ST_DATA;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                ST_DATA: state_q <= ST_DATA;
                ST_IDLE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign data_vld = (state_q == ST_DATA);
    assign advance  = data_vld;
    assign busy     = (state_q != ST_IDLE);
    assign rdy      = data_vld || (rdy_early && state_q == ST_WAIT && cnt_q == '0);
endmodule

// File: rtl/bsq_addr_gen.sv
`timescale 1ns/1ps
module bsq_addr_gen
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  burst_mode_e       mode,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] incr;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] nxt;

    always_comb begin
        incr = addr_q + 1'b1;
        mask = ADDR_W'(wrap_mask(mode));
        if (mode == BM_LINEAR)
            nxt = incr;
        else
            nxt = (addr_q & ~mask) | (incr & mask);
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= load_addr;
        else if (advance)
            addr_q <= nxt;
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/burst_seq_top.sv
`timescale 1ns/1ps
module burst_seq_top
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_wait,
    input  logic              cfg_rdy_early,
    input  logic              ce,
    input  logic              addr_valid_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_vld,
    output logic              rdy
);
    burst_cfg_t cfg_in;
    burst_cfg_t cfg_q;
    logic       busy;
    logic       start;
    logic       advance;

    assign cfg_in = '{mode: burst_mode_e'(cfg_mode), wait_cnt: cfg_wait, rdy_early: cfg_rdy_early};

    bsq_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .busy   (busy),
        .cfg_in (cfg_in),
        .cfg_o  (cfg_q)
    );

    bsq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .strobe_n  (addr_valid_n),
        .wait_cfg  (cfg_q.wait_cnt),
        .rdy_early (cfg_q.rdy_early),
        .start     (start),
        .advance   (advance),
        .busy      (busy),
        .data_vld  (data_vld),
        .rdy       (rdy)
    );

    bsq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (start_addr),
        .advance   (advance),
        .mode      (cfg_q.mode),
        .addr_o    (word_addr)
    );

    assign data_out = data_vld ? mem_q : '0;
endmodule

// File: rtl/bsq_checker.sv
`timescale 1ns/1ps
module bsq_checker
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              addr_valid_n,
    input logic              data_vld,
    input logic              rdy,
    input logic              busy,
    input logic [ADDR_W-1:0] word_addr,
    input burst_cfg_t        cfg
);
    AST_RDY_MATCHES_DATA: assert property (@(posedge clk) disable iff (rst)
        !cfg.rdy_early |-> (rdy == data_vld)); // R8

    AST_RDY_LEADS_DATA: assert property (@(posedge clk) disable iff (rst)
        cfg.rdy_early && $rose(rdy) && ce && addr_valid_n |=> data_vld); // R9

    AST_CE_ABORTS: assert property (@(posedge clk) disable iff (rst)
        !ce |=> (!rdy && !data_vld)); // R10

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        data_vld && $past(data_vld) && cfg.mode == BM_LINEAR
        |-> word_addr == ADDR_W'($past(word_addr) + 1'b1)); // R4

    AST_WRAP8_GROUP: assert property (@(posedge clk) disable iff (rst)
        data_vld && $past(data_vld) && cfg.mode == BM_WRAP8
        |-> word_addr[ADDR_W-1:3] == $past(word_addr[ADDR_W-1:3])); // R5

    AST_WRAP16_GROUP: assert property (@(posedge clk) disable iff (rst)
        data_vld && $past(data_vld) && cfg.mode == BM_WRAP16
        |-> word_addr[ADDR_W-1:4] == $past(word_addr[ADDR_W-1:4])); // R6

    AST_WRAP32_GROUP: assert property (@(posedge clk) disable iff (rst)
        data_vld && $past(data_vld) && cfg.mode == BM_WRAP32
        |-> word_addr[ADDR_W-1:5] == $past(word_addr[ADDR_W-1:5])); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg)); // R11
endmodule

bind burst_seq_top bsq_checker #(.ADDR_W(ADDR_W)) u_bsq_chk (
    .clk          (clk),
    .rst          (rst),
    .ce           (ce),
    .addr_valid_n (addr_valid_n),
    .data_vld     (data_vld),
    .rdy          (rdy),
    .busy         (busy),
    .word_addr    (word_addr),
    .cfg          (cfg_q)
);

// File: tb/burst_seq_top_tb_top.sv
`timescale 1ns/1ps
module burst_seq_top_tb_top;
    localparam int AW = 22;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [2:0]    cfg_wait = '0;
    logic          cfg_rdy_early = 1'b0;
    logic          ce = 1'b0;
    logic          addr_valid_n = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic [DW-1:0] mem_q;
    logic [AW-1:0] word_addr;
    logic [DW-1:0] data_out;
    logic          data_vld;
    logic          rdy;

    int checks = 0;
    int errs   = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
        return DW'(a * 3) ^ 16'h5A3C;
    endfunction

    assign mem_q = mem_f(word_addr);

    burst_seq_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr        (cfg_wr),
        .cfg_mode      (cfg_mode),
        .cfg_wait      (cfg_wait),
        .cfg_rdy_early (cfg_rdy_early),
        .ce            (ce),
        .addr_valid_n  (addr_valid_n),
        .start_addr    (start_addr),
        .mem_q         (mem_q),
        .word_addr     (word_addr),
        .data_out      (data_out),
        .data_vld      (data_vld),
        .rdy           (rdy)
    );

    function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] a, input int mode);
        int g;
        int off;
        if (mode == 0) return AW'(a + 1);
        g   = 4 << mode;
        off = int'(a) % g;
        return AW'(int'(a) - off + ((off + 1) % g));
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input int mode, input int wt, input int early);
        cfg_wr = 1'b1;
        cfg_mode = 2'(mode);
        cfg_wait = 3'(wt);
        cfg_rdy_early = 1'(early);
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic run_burst(input logic [AW-1:0] a, input int mode, input int wt,
                             input int early, input int nwords, input string tag);
        logic [AW-1:0] e;
        ce = 1'b1;
        addr_valid_n = 1'b0;
        start_addr = a;
        tick();
        addr_valid_n = 1'b1;
        start_addr = '0;
        for (int k = 0; k <= wt; k++) begin
            chk("R3 wait data_vld", 32'(data_vld), 32'd0);
            chk(early != 0 ? "R9 lead rdy" : "R8 rdy", 32'(rdy),
                32'((early != 0) && (k == wt)));
            tick();
        end
        e = a;
        for (int i = 0; i < nwords; i++) begin
            chk("R3 data_vld", 32'(data_vld), 32'd1);
            chk({tag, " word_addr"}, 32'(word_addr), 32'(e));
            chk("R12 data_out", 32'(data_out), 32'(mem_f(e)));
            chk(early != 0 ? "R9 rdy" : "R8 rdy", 32'(rdy), 32'd1);
            e = exp_next(e, mode);
            tick();
        end
    endtask

    task automatic end_burst();
        ce = 1'b0;
        tick();
        chk("R10 rdy", 32'(rdy), 32'd0);
        chk("R10 data_vld", 32'(data_vld), 32'd0);
        chk("R12 idle data_out", 32'(data_out), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1 rdy in reset", 32'(rdy), 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 rdy", 32'(rdy), 32'd0);
        chk("R1 data_vld", 32'(data_vld), 32'd0);
        chk("R1 data_out", 32'(data_out), 32'd0);
        run_burst(22'h100, 0, 7, 0, 4, "R1");
        end_burst();
    endtask

    task automatic t_modes();
        write_cfg(0, 2, 0);
        run_burst(22'h3E, 0, 2, 0, 6, "R4");
        end_burst();
        write_cfg(1, 0, 0);
        run_burst(22'h39, 1, 0, 0, 10, "R5");
        end_burst();
        write_cfg(2, 3, 1);
        run_burst(22'h1C, 2, 3, 1, 20, "R6");
        end_burst();
        write_cfg(3, 1, 1);
        run_burst(22'h3D, 3, 1, 1, 36, "R7");
        end_burst();
    endtask

    task automatic t_restart();
        write_cfg(0, 1, 0);
        run_burst(22'h200, 0, 1, 0, 3, "R2");
        run_burst(22'h300, 0, 1, 0, 3, "R2");
        end_burst();
    endtask

    task automatic t_cfg_locked();
        write_cfg(1, 4, 0);
        run_burst(22'h45, 1, 4, 0, 3, "R11");
        cfg_wr = 1'b1;
        cfg_mode = 2'd0;
        cfg_wait = 3'd0;
        cfg_rdy_early = 1'b1;
        tick();
        cfg_wr = 1'b0;
        chk("R11 burst continues", 32'(data_vld), 32'd1);
        end_burst();
        run_burst(22'h45, 1, 4, 0, 10, "R11");
        end_burst();
    endtask

    task automatic t_abort_wait();
        write_cfg(0, 4, 0);
        ce = 1'b1;
        addr_valid_n = 1'b0;
        start_addr = 22'h80;
        tick();
        addr_valid_n = 1'b1;
        tick();
        ce = 1'b0;
        tick();
        chk("R10 abort rdy", 32'(rdy), 32'd0);
        ce = 1'b1;
        for (int i = 0; i < 7; i++) begin
            tick();
            chk("R10 stays idle", 32'(data_vld), 32'd0);
        end
        ce = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        t_reset();
        t_modes();
        t_restart();
        t_cfg_locked();
        t_abort_wait();
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule